// File: doc/BRIEF.md
# Process-Tagged Page Translator

This block turns a 16-bit logical CPU address into a wider physical RAM address. The upper four address bits pick one of sixteen 4 KB logical pages. The block looks up that page in a small mapping table that it holds inside itself, and the entry it finds becomes the physical page number. The low twelve bits pass through unchanged. The table index combines three things: the running process tag, the logical page and the direction of the access. As a result, every process keeps its own map, and reads and writes to the same logical page can land in different physical pages. A page becomes read-only when its write mapping points at a scratch page. Two logical pages may also share one physical page.

A supervisor fills and inspects the table through a window in the address map. Inside that window, the address bits that form the table index are in a shuffled order. The table read is combinational, so a translation is ready within the first clock phase. Table writes are taken at the clock edge only while the high-phase qualifier is set. The table has no reset, so software must load every entry before it uses paged memory.

Top module: `pgx_xlate`

## Requirements
- R1: During a paged access (paged select high, table select low), ram_en is 1 and ram_addr equals {entry, cpu_addr[11:0]}. The entry is chosen by the logical page cpu_addr[15:12], the direction rwb (1 = read, 0 = write) and pid.
- R2: Different pid values that use the same page and direction select independent entries.
- R3: For the same pid and page, the read direction (rwb=1) and the write direction (rwb=0) select independent entries.
- R4: A table-window access decodes the index from the address as follows. The page is {cpu_addr[11], cpu_addr[10], cpu_addr[9], cpu_addr[12]}, from page bit 3 down to page bit 0. The direction is cpu_addr[8], and the tag is cpu_addr[PID_W-1:0]. Bits cpu_addr[7:PID_W] must be zero; otherwise the access misses, so a write is dropped and a read returns 0.
- R5: A window write (table select high, rwb=0) changes the table only at a clock edge where phase_hi is 1. With phase_hi at 0 it has no effect.
- R6: A window write is visible from the next cycle onward. A window read (rwb=1) returns the value most recently written to that entry, on cpu_dout, in the same cycle.
- R7: Two logical pages whose entries hold the same value translate to the same physical page.
- R8: With both selects low, ram_en is 0, ram_addr is 0 and cpu_dout is 0. cpu_dout is also 0 during a paged access and during a window write.
- R9: When both selects are high, the window access is performed and ram_en is 0, with ram_addr at 0.
- R10: A paged access with rwb=0 never modifies the table, whatever phase_hi and cpu_din are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; table writes are taken at its rising edge |
| cpu_addr | input | 16 | Logical CPU address |
| cpu_din | input | ENT_W | Data from the CPU, used for table writes |
| cpu_dout | output | ENT_W | Table entry read back through the window |
| rwb | input | 1 | Access direction: 1 = read, 0 = write |
| phase_hi | input | 1 | Second-phase qualifier for table writes |
| pid | input | PID_W | Current process tag |
| pg_sel | input | 1 | Current cycle is a paged memory access |
| tbl_sel | input | 1 | Current cycle accesses the table window |
| ram_en | output | 1 | Physical RAM access is valid |
| ram_addr | output | ENT_W+12 | Physical RAM address |

## Verification
The ram_en, ram_addr and cpu_dout outputs depend only on the current inputs and the table contents. They are due in the same cycle as their stimulus, so the bench drives inputs just after a rising edge and compares at the following falling edge. A table write is taken at the rising edge that ends its cycle. The reference model is therefore updated only after that cycle's comparison, and the effect is checked from the next cycle on. Read-backs that follow writes with phase_hi at 0, window misses and paged writes confirm through cpu_dout that the entry kept its value.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int OFFS_W = 12;
  localparam int PAGE_W = 4;
  localparam int CPU_AW = OFFS_W + PAGE_W;

  // Page number as laid out inside the supervisor window (shuffled order).
  function automatic logic [PAGE_W-1:0] win_page(input logic [CPU_AW-1:0] a);
    return {a[11], a[10], a[9], a[12]};
  endfunction

  // Logical page used by normal translation.
  function automatic logic [PAGE_W-1:0] log_page(input logic [CPU_AW-1:0] a);
    return a[CPU_AW-1:OFFS_W];
  endfunction
endpackage

// File: rtl/pgx_index_mux.sv
module pgx_index_mux
  import pgx_pkg::*;
#(
  parameter int PID_W = 6,
  localparam int IDX_W = PAGE_W + 1 + PID_W
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              rwb,
  input  logic [PID_W-1:0]  pid,
  input  logic              tbl_sel,
  output logic [IDX_W-1:0]  look_idx,
  output logic              win_hit
);
  logic [IDX_W-1:0] xl_idx;
  logic [IDX_W-1:0] wn_idx;

  always_comb begin
    xl_idx = {log_page(cpu_addr), rwb, pid};
    wn_idx = {win_page(cpu_addr), cpu_addr[8], cpu_addr[PID_W-1:0]};
    look_idx = tbl_sel ? wn_idx : xl_idx;
  end

  generate
    if (PID_W < 8) begin : g_narrow
      assign win_hit = (cpu_addr[7:PID_W] == '0);
    end else begin : g_full
      assign win_hit = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pgx_table.sv
module pgx_table #(
  parameter int IDX_W = 11,
  parameter int ENT_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [ENT_W-1:0] wdata,
  output logic [ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
#(
  parameter int PID_W = 6,
  parameter int ENT_W = 8,
  localparam int IDX_W = PAGE_W + 1 + PID_W,
  localparam int PA_W = ENT_W + OFFS_W
) (
  input  logic              clk,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [ENT_W-1:0]  cpu_din,
  output logic [ENT_W-1:0]  cpu_dout,
  input  logic              rwb,
  input  logic              phase_hi,
  input  logic [PID_W-1:0]  pid,
  input  logic              pg_sel,
  input  logic              tbl_sel,
  output logic              ram_en,
  output logic [PA_W-1:0]   ram_addr
);
  logic [IDX_W-1:0] look_idx;
  logic             win_hit;
  logic [ENT_W-1:0] entry;
  logic             tbl_wr;

  pgx_index_mux #(.PID_W(PID_W)) u_idx (
    .cpu_addr (cpu_addr),
    .rwb      (rwb),
    .pid      (pid),
    .tbl_sel  (tbl_sel),
    .look_idx (look_idx),
    .win_hit  (win_hit)
  );

  assign tbl_wr = tbl_sel & ~rwb & phase_hi & win_hit;

  pgx_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_tab (
    .clk   (clk),
    .we    (tbl_wr),
    .idx   (look_idx),
    .wdata (cpu_din),
    .rdata (entry)
  );

  always_comb begin
    ram_en   = pg_sel & ~tbl_sel;
    ram_addr = ram_en ? {entry, cpu_addr[OFFS_W-1:0]} : '0;
    cpu_dout = (tbl_sel & rwb & win_hit) ? entry : '0;
  end
endmodule

// File: rtl/pgx_xlate_chk.sv
module pgx_xlate_chk #(
  parameter int ENT_W = 8,
  parameter int PA_W = 20
) (
  input logic             clk,
  input logic [15:0]      cpu_addr,
  input logic [ENT_W-1:0] cpu_din,
  input logic [ENT_W-1:0] cpu_dout,
  input logic             rwb,
  input logic             pg_sel,
  input logic             tbl_sel,
  input logic             ram_en,
  input logic [PA_W-1:0]  ram_addr,
  input logic             tbl_wr
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!armed)
    (!pg_sel && !tbl_sel) |-> (!ram_en && ram_addr == '0 && cpu_dout == '0)); // R8

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!armed)
    ram_en |-> (ram_addr[11:0] == cpu_addr[11:0])); // R1

  AST_WINDOW_WINS: assert property (@(posedge clk) disable iff (!armed)
    tbl_sel |-> (!ram_en && ram_addr == '0)); // R9

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!armed)
    tbl_wr |=> ((tbl_sel && rwb && cpu_addr == $past(cpu_addr)) -> cpu_dout == $past(cpu_din))); // R6

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!armed)
    (tbl_sel && rwb) |=> ((tbl_sel && rwb && $stable(cpu_addr)) -> $stable(cpu_dout))); // R5
endmodule

bind pgx_xlate pgx_xlate_chk #(.ENT_W(ENT_W), .PA_W(PA_W)) u_chk (
  .clk      (clk),
  .cpu_addr (cpu_addr),
  .cpu_din  (cpu_din),
  .cpu_dout (cpu_dout),
  .rwb      (rwb),
  .pg_sel   (pg_sel),
  .tbl_sel  (tbl_sel),
  .ram_en   (ram_en),
  .ram_addr (ram_addr),
  .tbl_wr   (tbl_wr)
);

// File: tb/sim_pgx_xlate.sv
`timescale 1ns/1ps
module sim_pgx_xlate;
  logic        clk = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_din = '0;
  logic [7:0]  cpu_dout;
  logic        rwb = 1'b1;
  logic        phase_hi = 1'b0;
  logic [5:0]  pid = '0;
  logic        pg_sel = 1'b0;
  logic        tbl_sel = 1'b0;
  logic        ram_en;
  logic [19:0] ram_addr;

  int checks = 0;
  int failures = 0;
  int model [2048];

  always #5 clk = ~clk;

  pgx_xlate u0 (
    .clk(clk), .cpu_addr(cpu_addr), .cpu_din(cpu_din), .cpu_dout(cpu_dout),
    .rwb(rwb), .phase_hi(phase_hi), .pid(pid), .pg_sel(pg_sel),
    .tbl_sel(tbl_sel), .ram_en(ram_en), .ram_addr(ram_addr)
  );

  function automatic int mi(input int pg, input int dir, input int tag);
    return pg * 128 + dir * 64 + tag;
  endfunction

  // Window address built from the layout in R4.
  function automatic logic [15:0] waddr(input int pg, input int dir, input int tag, input int hi2);
    int a;
    a = 'hC000;
    a += ((pg >> 0) & 1) * 'h1000;
    a += ((pg >> 3) & 1) * 'h0800;
    a += ((pg >> 2) & 1) * 'h0400;
    a += ((pg >> 1) & 1) * 'h0200;
    a += dir * 'h100 + hi2 * 64 + tag;
    return a[15:0];
  endfunction

  task automatic step(input string tag, input bit ps, input bit ts, input bit rw,
                      input bit ph, input logic [15:0] a, input logic [7:0] d,
                      input logic [5:0] p);
    int pg, dir, tg, e;
    bit hit;
    bit     x_en;
    int     x_addr, x_dout;
    pg_sel = ps; tbl_sel = ts; rwb = rw; phase_hi = ph;
    cpu_addr = a; cpu_din = d; pid = p;
    @(negedge clk);
    pg  = 8 * a[11] + 4 * a[10] + 2 * a[9] + a[12];
    dir = a[8];
    tg  = a[5:0];
    hit = (a[7:6] == 2'b00);
    x_en = 0; x_addr = 0; x_dout = 0;
    if (ts) begin
      if (rw && hit) x_dout = model[mi(pg, dir, tg)];
    end else if (ps) begin
      x_en = 1;
      e = model[mi(a[15:12], rw, p)];
      x_addr = e * 4096 + a[11:0];
    end
    checks++;
    if (ram_en !== x_en || ram_addr !== x_addr[19:0] || cpu_dout !== x_dout[7:0]) begin
      failures++;
      $display("FAIL %s: en=%0b addr=%05h dout=%02h expected en=%0b addr=%05h dout=%02h",
               tag, ram_en, ram_addr, cpu_dout, x_en, x_addr[19:0], x_dout[7:0]);
    end
    if (ts && !rw && ph && hit) model[mi(pg, dir, tg)] = d;
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    // Idle outputs before the table is loaded.
    step("R8 idle", 0, 0, 1, 0, 16'h1234, 8'h00, 6'd0);
    // Load the whole table through the shuffled window.
    for (int pg = 0; pg < 16; pg++)
      for (int dir = 0; dir < 2; dir++)
        for (int t = 0; t < 64; t++)
          step("R4 load", 0, 1, 0, 1, waddr(pg, dir, t, 0),
               8'((mi(pg, dir, t) * 73 + 11) % 256), 6'd0);
    // Read-back of several entries.
    step("R4 rd", 0, 1, 1, 0, waddr(9, 0, 17, 0), 8'h00, 6'd0);
    step("R4 rd", 0, 1, 1, 1, waddr(6, 1, 63, 0), 8'h00, 6'd0);
    step("R4 rd", 0, 1, 1, 0, waddr(1, 1, 2, 0), 8'h00, 6'd0);
    // Translations.
    step("R1 xl", 1, 0, 1, 0, 16'h5ABC, 8'h00, 6'd3);
    step("R1 xl", 1, 0, 1, 1, 16'hF001, 8'h00, 6'd40);
    step("R2 pid", 1, 0, 1, 0, 16'h5ABC, 8'h00, 6'd4);
    step("R2 pid", 1, 0, 1, 0, 16'h5ABC, 8'h00, 6'd63);
    step("R3 dir", 1, 0, 0, 0, 16'h5ABC, 8'h00, 6'd3);
    step("R3 dir", 1, 0, 0, 1, 16'h0FFF, 8'h00, 6'd0);
    // R5: low-phase write has no effect.
    step("R5 wr", 0, 1, 0, 0, waddr(2, 0, 5, 0), 8'hEE, 6'd0);
    step("R5 rd", 0, 1, 1, 0, waddr(2, 0, 5, 0), 8'h00, 6'd0);
    // R6: write then read next cycle.
    step("R6 wr", 0, 1, 0, 1, waddr(2, 0, 5, 0), 8'h5A, 6'd0);
    step("R6 rd", 0, 1, 1, 0, waddr(2, 0, 5, 0), 8'h00, 6'd0);
    step("R6 xl", 1, 0, 0, 0, 16'h2345, 8'h00, 6'd5);
    // R4 window miss: upper tag bits nonzero.
    step("R4 miss wr", 0, 1, 0, 1, waddr(2, 0, 5, 1), 8'h11, 6'd0);
    step("R4 miss rd", 0, 1, 1, 0, waddr(2, 0, 5, 1), 8'h00, 6'd0);
    step("R4 miss keep", 0, 1, 1, 0, waddr(2, 0, 5, 0), 8'h00, 6'd0);
    // R7: alias two pages to one physical page.
    step("R7 wr", 0, 1, 0, 1, waddr(3, 1, 9, 0), 8'hC3, 6'd0);
    step("R7 wr", 0, 1, 0, 1, waddr(12, 1, 9, 0), 8'hC3, 6'd0);
    step("R7 xl", 1, 0, 1, 0, 16'h3010, 8'h00, 6'd9);
    step("R7 xl", 1, 0, 1, 0, 16'hC010, 8'h00, 6'd9);
    // R9: both selects.
    step("R9 both", 1, 1, 1, 0, waddr(7, 0, 8, 0), 8'h00, 6'd8);
    step("R9 both wr", 1, 1, 0, 1, waddr(7, 0, 8, 0), 8'h77, 6'd8);
    step("R9 rd", 0, 1, 1, 0, waddr(7, 0, 8, 0), 8'h00, 6'd0);
    // R10: paged write never touches the table.
    step("R10 pwr", 1, 0, 0, 1, waddr(4, 0, 1, 0), 8'h99, 6'd1);
    step("R10 rd", 0, 1, 1, 0, waddr(4, 0, 1, 0), 8'h00, 6'd0);
    step("R10 rd", 0, 1, 1, 0, waddr(12, 0, 1, 0), 8'h00, 6'd0);
    // R8 again: quiet outputs and window write returns no data.
    step("R8 idle", 0, 0, 0, 1, 16'hFFFF, 8'hFF, 6'd63);
    step("R8 twr", 0, 1, 0, 0, waddr(0, 0, 0, 0), 8'h00, 6'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule